// File: doc/BRIEF.md
# Posted Write Ordering Scheduler

The block holds up to eight pending posted memory writes and chooses which one is committed to memory next. Requests arrive on a valid/ready input. Each carries a requester identifier, two ordering hints (a relaxed hint and an identifier-scoped hint), a target address and a tag. Each accepted request sits in a fixed slot until it is committed. A memory-side mask reports, one bit per slot, which slots could be committed this cycle, for example because their target bank is idle.

A slot may be committed only when the ordering rules let it overtake every older pending write. Without hints, writes commit strictly in arrival order. A relaxed write may overtake anything older, unless a configuration input disables relaxed passing. An identifier-scoped write may overtake only older writes from a different requester. This means a plain completion notice that follows a burst of relaxed data writes is held until the whole burst has gone. When several slots qualify, the oldest one is granted. The committed tag and address appear on a registered output with a one-cycle valid pulse.

Top module: `pw_order_sched`

## Requirements
- R1: A synchronous active-high reset empties every slot. The reset edge produces no grant, so `grantValid` is low after it. After reset, `inReady` is high and `pendValid` is all zeros.
- R2: A request is accepted at a clock edge when `inValid` and `inReady` are both high. It is placed in the lowest-numbered slot that was free before that edge, and that bit of `pendValid` is high after the edge. Bit k of `commitMask` and of `pendValid` refers to slot k.
- R3: `inReady` is low exactly when all eight slots are occupied. Occupancy is judged on the current state, so a slot freed at the same edge does not count as free.
- R4: A pending write whose relaxed hint is not in effect and whose identifier-scoped hint is clear is never granted while any older write is still pending.
- R5: A write with the relaxed hint set, while `roDisable` is low, may be granted ahead of any older pending writes.
- R6: A write with the identifier-scoped hint set may pass an older pending write only when the two requester identifiers differ.
- R7: While `roDisable` is high, the relaxed hint gives no bypass.
- R8: A slot is eligible when, for every older pending slot, at least one passing rule allows overtaking it. The oldest pending slot is always eligible.
- R9: At most one slot is granted per edge. It is the oldest slot that is both eligible and has its `commitMask` bit set, and no grant occurs when there is no such slot.
- R10: After a granting edge, `grantValid` is high for one cycle and carries that slot's tag and address on `grantTag` and `grantAddr`. The slot is freed at the same edge, so its `pendValid` bit is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| roDisable | input | 1 | Turns off relaxed-hint passing |
| inValid | input | 1 | Request valid |
| inReady | output | 1 | A free slot exists |
| inId | input | ID_W | Requester identifier |
| inRo | input | 1 | Relaxed ordering hint |
| inIdo | input | 1 | Identifier-scoped ordering hint |
| inAddr | input | ADDR_W | Target address |
| inTag | input | TAG_W | Request tag |
| commitMask | input | 8 | Per-slot committable flags from the memory side |
| pendValid | output | 8 | Per-slot occupancy |
| grantValid | output | 1 | One-cycle commit pulse |
| grantTag | output | TAG_W | Tag of the committed write |
| grantAddr | output | ADDR_W | Address of the committed write |

## Verification
A wrong age relation or a stale occupancy bit shows up at the very next granting edge. Either a plain write commits while an older one is pending, or the grant goes to a younger slot than the oldest committable candidate. The `grantTag` that follows the edge exposes this within one cycle. A slot that is wrongly allocated or not freed is visible on `pendValid` right after the edge that should have changed it. If the slot is never freed, `inReady` also stays low once eight slots appear used.

// File: rtl/pw_order_pkg.sv
package pw_order_pkg;
  localparam int SLOTS  = 8;
  localparam int SLOT_W = $clog2(SLOTS);

  typedef logic [SLOTS-1:0] slot_vec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      alloc;
    slot_vec_t allocOh;
    logic      grant;
    slot_vec_t grantOh;
  } sched_strobe_t;
endpackage

// File: rtl/pw_order_store.sv
module pw_order_store
  import pw_order_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  sched_strobe_t                 strb,
  input  logic [ID_W-1:0]               inId,
  input  logic                          inRo,
  input  logic                          inIdo,
  input  logic [ADDR_W-1:0]             inAddr,
  input  logic [TAG_W-1:0]              inTag,
  output slot_vec_t                     validQ,
  output logic [SLOTS-1:0][SLOTS-1:0]   olderQ,
  output slot_vec_t                     roQ,
  output slot_vec_t                     idoQ,
  output logic [SLOTS-1:0][ID_W-1:0]    idQ,
  output logic                          grantValidQ,
  output logic [TAG_W-1:0]              grantTagQ,
  output logic [ADDR_W-1:0]             grantAddrQ
);
  logic [SLOTS-1:0][TAG_W-1:0]  tagQ;
  logic [SLOTS-1:0][ADDR_W-1:0] addrQ;
  logic [SLOTS-1:0][SLOTS-1:0]  olderD;
  slot_vec_t                    freeMask;
  logic [TAG_W-1:0]             tagSel;
  logic [ADDR_W-1:0]            addrSel;

  assign freeMask = strb.grant ? strb.grantOh : '0;

  // age matrix: olderD[r][c] means slot c arrived before slot r
  always_comb begin
    for (int r = 0; r < SLOTS; r++) begin
      for (int c = 0; c < SLOTS; c++) begin
        olderD[r][c] = olderQ[r][c];
        if (strb.alloc && strb.allocOh[c]) olderD[r][c] = 1'b0;
        if (strb.alloc && strb.allocOh[r]) olderD[r][c] = validQ[c] & ~freeMask[c];
      end
    end
  end

  always_comb begin
    tagSel  = '0;
    addrSel = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (strb.grantOh[i]) begin
        tagSel  = tagSel | tagQ[i];
        addrSel = addrSel | addrQ[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validQ      <= '0;
      olderQ      <= '0;
      grantValidQ <= 1'b0;
      grantTagQ   <= '0;
      grantAddrQ  <= '0;
    end else begin
      olderQ      <= olderD;
      grantValidQ <= strb.grant;
      if (strb.grant) begin
        grantTagQ  <= tagSel;
        grantAddrQ <= addrSel;
      end
      for (int i = 0; i < SLOTS; i++) begin
        if (freeMask[i]) validQ[i] <= 1'b0;
        if (strb.alloc && strb.allocOh[i]) validQ[i] <= 1'b1;
      end
    end
  end

  // payload fields, written on allocation only
  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++) begin
      if (strb.alloc && strb.allocOh[i]) begin
        idQ[i]   <= inId;
        roQ[i]   <= inRo;
        idoQ[i]  <= inIdo;
        tagQ[i]  <= inTag;
        addrQ[i] <= inAddr;
      end
    end
  end

  p_alloc_free_r2: assert property (@(posedge clk) disable iff (rst)
    strb.alloc |-> ($onehot(strb.allocOh) && ((strb.allocOh & validQ) == '0)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    strb.alloc |-> !(&validQ));

  p_grant_frees_r10: assert property (@(posedge clk) disable iff (rst)
    strb.grant |=> (grantValidQ && ((validQ & $past(strb.grantOh)) == '0)));

  p_grant_pending_r9: assert property (@(posedge clk) disable iff (rst)
    strb.grant |-> ((strb.grantOh & ~validQ) == '0));
endmodule

// File: rtl/pw_order_ctrl.sv
module pw_order_ctrl
  import pw_order_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        inValid,
  input  logic                        roDisable,
  input  slot_vec_t                   commitMask,
  input  slot_vec_t                   validQ,
  input  logic [SLOTS-1:0][SLOTS-1:0] olderQ,
  input  slot_vec_t                   roQ,
  input  slot_vec_t                   idoQ,
  input  logic [SLOTS-1:0][ID_W-1:0]  idQ,
  output logic                        inReady,
  output sched_strobe_t               strb
);
  logic [SLOTS-1:0][SLOTS-1:0] passMat;
  slot_vec_t                   elig;
  slot_vec_t                   cand;
  slot_vec_t                   grantOh;
  slot_vec_t                   allocOh;
  logic                        found;

  assign inReady = ~(&validQ);

  // lowest free slot
  always_comb begin
    allocOh = '0;
    found   = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (!validQ[i] && !found) begin
        allocOh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  // passing rules: row i may overtake column j
  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      for (int j = 0; j < SLOTS; j++) begin
        passMat[i][j] = (roQ[i] & ~roDisable) | (idoQ[i] & (idQ[i] != idQ[j]));
      end
    end
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      elig[i] = validQ[i] & (&(passMat[i] | ~(validQ & olderQ[i])));
    end
    cand = elig & commitMask;
    for (int i = 0; i < SLOTS; i++) begin
      grantOh[i] = cand[i] & ~(|(cand & olderQ[i]));
    end
  end

  always_comb begin
    strb.alloc   = inValid & inReady;
    strb.allocOh = allocOh;
    strb.grant   = |grantOh;
    strb.grantOh = grantOh;
  end

  p_one_grant_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb.grantOh));

  for (genvar a = 0; a < SLOTS; a++) begin : g_chk
    p_oldest_eligible_r8: assert property (@(posedge clk) disable iff (rst)
      (validQ[a] && ((olderQ[a] & validQ) == '0)) |-> elig[a]);

    p_plain_waits_r4: assert property (@(posedge clk) disable iff (rst)
      (strb.grantOh[a] && !(roQ[a] && !roDisable) && !idoQ[a])
        |-> ((olderQ[a] & validQ) == '0));
  end
endmodule

// File: rtl/pw_order_sched.sv
module pw_order_sched
  import pw_order_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              roDisable,
  input  logic              inValid,
  output logic              inReady,
  input  logic [ID_W-1:0]   inId,
  input  logic              inRo,
  input  logic              inIdo,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [TAG_W-1:0]  inTag,
  input  logic [SLOTS-1:0]  commitMask,
  output logic [SLOTS-1:0]  pendValid,
  output logic              grantValid,
  output logic [TAG_W-1:0]  grantTag,
  output logic [ADDR_W-1:0] grantAddr
);
  sched_strobe_t               strb;
  slot_vec_t                   validQ;
  logic [SLOTS-1:0][SLOTS-1:0] olderQ;
  slot_vec_t                   roQ;
  slot_vec_t                   idoQ;
  logic [SLOTS-1:0][ID_W-1:0]  idQ;

  pw_order_ctrl #(.ID_W(ID_W)) i_ctrl (
    .clk        (clk),
    .rst        (rst),
    .inValid    (inValid),
    .roDisable  (roDisable),
    .commitMask (commitMask),
    .validQ     (validQ),
    .olderQ     (olderQ),
    .roQ        (roQ),
    .idoQ       (idoQ),
    .idQ        (idQ),
    .inReady    (inReady),
    .strb       (strb)
  );

  pw_order_store #(.ID_W(ID_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) i_store (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .inId        (inId),
    .inRo        (inRo),
    .inIdo       (inIdo),
    .inAddr      (inAddr),
    .inTag       (inTag),
    .validQ      (validQ),
    .olderQ      (olderQ),
    .roQ         (roQ),
    .idoQ        (idoQ),
    .idQ         (idQ),
    .grantValidQ (grantValid),
    .grantTagQ   (grantTag),
    .grantAddrQ  (grantAddr)
  );

  assign pendValid = validQ;

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !grantValid);
endmodule

// File: tb/test_pw_order_sched.sv
module test_pw_order_sched;
  import pw_order_pkg::*;
  localparam int ID_W   = 8;
  localparam int ADDR_W = 32;
  localparam int TAG_W  = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              roDisable = 1'b0;
  logic              inValid = 1'b0;
  logic              inReady;
  logic [ID_W-1:0]   inId = '0;
  logic              inRo = 1'b0;
  logic              inIdo = 1'b0;
  logic [ADDR_W-1:0] inAddr = '0;
  logic [TAG_W-1:0]  inTag = '0;
  slot_vec_t         commitMask = '0;
  slot_vec_t         pendValid;
  logic              grantValid;
  logic [TAG_W-1:0]  grantTag;
  logic [ADDR_W-1:0] grantAddr;

  pw_order_sched #(.ID_W(ID_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W)) i_pw_order_sched (
    .clk(clk), .rst(rst), .roDisable(roDisable), .inValid(inValid), .inReady(inReady),
    .inId(inId), .inRo(inRo), .inIdo(inIdo), .inAddr(inAddr), .inTag(inTag),
    .commitMask(commitMask), .pendValid(pendValid), .grantValid(grantValid),
    .grantTag(grantTag), .grantAddr(grantAddr)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit doneFlag = 1'b0;

  // reference scoreboard
  bit               mValid [SLOTS];
  logic [ID_W-1:0]  mId    [SLOTS];
  bit               mRo    [SLOTS];
  bit               mIdo   [SLOTS];
  logic [TAG_W-1:0] mTag   [SLOTS];
  int               mSeq   [SLOTS];
  int               seqNext = 0;

  typedef struct packed {
    logic             v;
    logic [ID_W-1:0]  id;
    logic             ro;
    logic             ido;
    logic [TAG_W-1:0] tag;
    logic [SLOTS-1:0] mask;
    logic             roDis;
    logic             expV;
    logic [TAG_W-1:0] expTag;
  } vec_t;

  // burst/notice, identifier-scoped and disable scenarios
  localparam vec_t VECS [16] = '{
    '{1'b1, 8'd1, 1'b1, 1'b0, 8'd1, 8'h00, 1'b0, 1'b0, 8'd0},
    '{1'b1, 8'd1, 1'b0, 1'b0, 8'd2, 8'h00, 1'b0, 1'b0, 8'd0},
    '{1'b1, 8'd2, 1'b1, 1'b0, 8'd3, 8'h02, 1'b0, 1'b0, 8'd0},
    '{1'b0, 8'd0, 1'b0, 1'b0, 8'd0, 8'h04, 1'b0, 1'b1, 8'd3},
    '{1'b0, 8'd0, 1'b0, 1'b0, 8'd0, 8'h03, 1'b0, 1'b1, 8'd1},
    '{1'b1, 8'd5, 1'b0, 1'b1, 8'd4, 8'h02, 1'b0, 1'b1, 8'd2},
    '{1'b1, 8'd5, 1'b0, 1'b1, 8'd5, 8'h00, 1'b0, 1'b0, 8'd0},
    '{1'b1, 8'd6, 1'b0, 1'b1, 8'd6, 8'h02, 1'b0, 1'b0, 8'd0},
    '{1'b0, 8'd0, 1'b0, 1'b0, 8'd0, 8'h04, 1'b0, 1'b1, 8'd6},
    '{1'b0, 8'd0, 1'b0, 1'b0, 8'd0, 8'h03, 1'b0, 1'b1, 8'd4},
    '{1'b0, 8'd0, 1'b0, 1'b0, 8'd0, 8'h02, 1'b0, 1'b1, 8'd5},
    '{1'b1, 8'd1, 1'b1, 1'b0, 8'd7, 8'h00, 1'b0, 1'b0, 8'd0},
    '{1'b1, 8'd1, 1'b1, 1'b0, 8'd8, 8'h00, 1'b0, 1'b0, 8'd0},
    '{1'b0, 8'd0, 1'b0, 1'b0, 8'd0, 8'h02, 1'b1, 1'b0, 8'd0},
    '{1'b0, 8'd0, 1'b0, 1'b0, 8'd0, 8'h02, 1'b0, 1'b1, 8'd8},
    '{1'b0, 8'd0, 1'b0, 1'b0, 8'd0, 8'h01, 1'b0, 1'b1, 8'd7}
  };

  function automatic logic [ADDR_W-1:0] addrOf(input logic [TAG_W-1:0] t);
    return ADDR_W'(32'h1000_0000) + ADDR_W'({t, 2'b00});
  endfunction

  task automatic chk(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic printSummary();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
  endtask

  function automatic int pickGrant(input slot_vec_t mask, input bit roDis);
    int best;
    bit ok;
    bit p;
    best = -1;
    for (int i = 0; i < SLOTS; i++) begin
      if (mValid[i] && mask[i]) begin
        ok = 1'b1;
        for (int j = 0; j < SLOTS; j++) begin
          if (mValid[j] && mSeq[j] < mSeq[i]) begin
            p = (mRo[i] && !roDis) || (mIdo[i] && mId[i] != mId[j]);
            if (!p) ok = 1'b0;
          end
        end
        if (ok && (best < 0 || mSeq[i] < mSeq[best])) best = i;
      end
    end
    return best;
  endfunction

  task automatic step(input bit v, input logic [ID_W-1:0] id, input bit ro, input bit ido,
                      input logic [TAG_W-1:0] tag, input slot_vec_t mask, input bit roDis);
    int g;
    int k;
    int older;
    int freeSlot;
    bit full;
    bit plain;
    slot_vec_t expPend;
    inValid = v; inId = id; inRo = ro; inIdo = ido; inTag = tag;
    inAddr = addrOf(tag); commitMask = mask; roDisable = roDis;
    #1;
    full = 1'b1;
    freeSlot = -1;
    for (int i = 0; i < SLOTS; i++) begin
      if (!mValid[i]) begin
        full = 1'b0;
        if (freeSlot < 0) freeSlot = i;
      end
    end
    chk(inReady == !full, "R3 inReady versus occupancy", 64'(inReady), 64'(!full));
    g = pickGrant(mask, roDis);
    @(posedge clk);
    @(negedge clk);
    chk(grantValid == (g >= 0), "R9 R10 grant pulse", 64'(grantValid), 64'(g >= 0));
    if (g >= 0) begin
      chk(grantTag == mTag[g], "R9 oldest eligible tag", 64'(grantTag), 64'(mTag[g]));
      chk(grantAddr == addrOf(mTag[g]), "R10 grant address", 64'(grantAddr), 64'(addrOf(mTag[g])));
    end
    if (grantValid) begin
      k = -1;
      for (int i = 0; i < SLOTS; i++) if (mValid[i] && mTag[i] == grantTag) k = i;
      if (k >= 0) begin
        plain = !(mRo[k] && !roDis) && !mIdo[k];
        if (plain) begin
          older = 0;
          for (int j = 0; j < SLOTS; j++) if (mValid[j] && mSeq[j] < mSeq[k]) older++;
          chk(older == 0, "R4 plain write passed older pending", 64'(older), 64'd0);
        end
      end
    end
    if (g >= 0) mValid[g] = 1'b0;
    if (v && !full) begin
      mValid[freeSlot] = 1'b1; mId[freeSlot] = id; mRo[freeSlot] = ro;
      mIdo[freeSlot] = ido; mTag[freeSlot] = tag; mSeq[freeSlot] = seqNext;
      seqNext++;
    end
    for (int i = 0; i < SLOTS; i++) expPend[i] = mValid[i];
    chk(pendValid == expPend, "R2 R10 slot occupancy", 64'(pendValid), 64'(expPend));
  endtask

  task automatic doReset();
    rst = 1'b1; inValid = 1'b0; commitMask = '1;
    @(posedge clk);
    @(negedge clk);
    chk(grantValid == 1'b0, "R1 no grant at reset", 64'(grantValid), 64'd0);
    chk(pendValid == '0, "R1 slots empty", 64'(pendValid), 64'd0);
    chk(inReady == 1'b1, "R1 ready after reset", 64'(inReady), 64'd1);
    for (int i = 0; i < SLOTS; i++) mValid[i] = 1'b0;
    rst = 1'b0;
    commitMask = '0;
  endtask

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    printSummary();
    $finish;
  end

  initial begin
    int tagCtr;
    for (int i = 0; i < SLOTS; i++) begin mValid[i] = 1'b0; mSeq[i] = 0; end
    doReset();

    // table walk: R4 R5 R6 R7 R8 R9
    for (int r = 0; r < 16; r++) begin
      step(VECS[r].v, VECS[r].id, VECS[r].ro, VECS[r].ido, VECS[r].tag, VECS[r].mask, VECS[r].roDis);
      chk(grantValid == VECS[r].expV, $sformatf("R9 table row %0d valid", r),
          64'(grantValid), 64'(VECS[r].expV));
      if (VECS[r].expV)
        chk(grantTag == VECS[r].expTag, $sformatf("R5 R6 R7 table row %0d tag", r),
            64'(grantTag), 64'(VECS[r].expTag));
    end

    // fill past capacity: R3, then strict in-order drain of plain writes: R4
    for (int n = 0; n < 9; n++) step(1'b1, 8'd3, 1'b0, 1'b0, TAG_W'(100 + n), '0, 1'b0);
    chk(inReady == 1'b0, "R3 full queue not ready", 64'(inReady), 64'd0);
    for (int n = 0; n < 8; n++) begin
      step(1'b0, '0, 1'b0, 1'b0, '0, '1, 1'b0);
      chk(grantTag == TAG_W'(100 + n), "R4 in-order drain", 64'(grantTag), 64'(100 + n));
    end
    step(1'b0, '0, 1'b0, 1'b0, '0, '1, 1'b0);
    chk(grantValid == 1'b0, "R3 ninth request was dropped", 64'(grantValid), 64'd0);

    // reset with pending, committable entries: R1
    for (int n = 0; n < 3; n++) step(1'b1, 8'd2, 1'b1, 1'b0, TAG_W'(50 + n), '0, 1'b0);
    doReset();

    // randomised traffic against scoreboard: R2 R4 R5 R6 R7 R8 R9
    tagCtr = 0;
    for (int c = 0; c < 4000; c++) begin
      bit pv;
      pv = ($urandom_range(0, 3) != 0);
      step(pv, ID_W'($urandom_range(0, 3)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
           TAG_W'(tagCtr), slot_vec_t'($urandom_range(0, 255)), ($urandom_range(0, 7) == 0));
      if (pv) tagCtr++;
    end

    printSummary();
    $finish;
  end
endmodule